// File: doc/BRIEF.md
# Codec Clock Divider Chain

This block turns one fast master clock into three rate enables for a codec. The first stage divides the master clock by an integer ratio from 1 to 5 to form an internal master rate. Two later stages count enables of that internal rate, not raw master cycles. One produces a serial bit-clock enable at a power-of-two ratio between 1 and 8. The other produces a one-cycle sample strobe at a ratio between 256 and 2048. All three outputs are single-cycle enables in the master clock domain, so downstream logic stays on one clock tree.

A 7-bit setting, loaded by a write strobe, selects all three ratios. Each stage keeps its own active ratio. It adopts a newly written ratio only when its counter reaches terminal count, so a period that has already started always completes at the ratio it began with.

Top module: `codec_clkdiv_chain`

## Requirements
- R1: Master-divide codes 0, 1, 2, 3 and 4 make `dmclk_en` pulse once every 1, 2, 3, 4 and 5 master cycles respectively.
- R2: Master-divide codes 5, 6 and 7 behave as divide-by-one, with `dmclk_en` high on every master cycle.
- R3: Serial-divide codes 0, 1, 2 and 3 make `sclk_en` pulse once every 8, 4, 2 and 1 `dmclk_en` pulses respectively.
- R4: Sample-divide codes 0, 1, 2 and 3 make `fs_strobe` pulse once every 2048, 1024, 512 and 256 `dmclk_en` pulses respectively.
- R5: After reset the setting is all zeros: divide-by-one, serial /8, sample /2048. `dmclk_en` is high on the first cycle after reset. The first `sclk_en` comes 7 master cycles later and the first `fs_strobe` 2047 master cycles later.
- R6: `sclk_en` and `fs_strobe` are each one master cycle wide and are only asserted in a cycle where `dmclk_en` is asserted.
- R7: In `cfg_data`, bits 6:4 hold the master-divide code, bits 3:2 the serial-divide code and bits 1:0 the sample-divide code.
- R8: A new setting reaches each stage at that stage's next terminal count. The period already in progress finishes at the old ratio, and the following period uses the new one.
- R9: While `cfg_wr` is low, changes on `cfg_data` have no effect on any output rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Loads `cfg_data` into the setting register |
| cfg_data | input | 7 | Ratio setting: master [6:4], serial [3:2], sample [1:0] |
| dmclk_en | output | 1 | Internal master rate enable |
| sclk_en | output | 1 | Serial bit-clock enable |
| fs_strobe | output | 1 | One-cycle sample-rate strobe |

## Verification
The assertions assume that each stage's requested ratio is never zero. The decode functions guarantee this for every 7-bit setting, so the bench writes any code freely, including the three unused master-divide codes. The assertions also assume that the active ratios only move at terminal count. The bench therefore writes settings at arbitrary phases, including mid-period, and judges each rate only after the stage has passed a terminal count. The sample-divide code is held at its fastest value while the master and serial codes are swept, which keeps each measurement short.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

  typedef struct packed {
    logic [2:0] mdiv;
    logic [1:0] sdiv;
    logic [1:0] fsdiv;
  } ccd_cfg_t;

  // master stage: codes 0..4 map to ratio code+1, the rest to one
  function automatic int master_ratio(input logic [2:0] code);
    int r;
    case (code)
      3'd0: r = 1;
      3'd1: r = 2;
      3'd2: r = 3;
      3'd3: r = 4;
      3'd4: r = 5;
      default: r = 1;
    endcase
    return r;
  endfunction

  // later stages: slowest ratio at code zero, halving per code step
  function automatic int halving_ratio(input int slowest, input logic [1:0] code);
    return slowest >> code;
  endfunction

endpackage

// File: rtl/ccd_cfg_reg.sv
module ccd_cfg_reg
  import ccd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic [6:0] din,
  output ccd_cfg_t q
);

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= ccd_cfg_t'(din);
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R9

endmodule

// File: rtl/ccd_div_stage.sv
module ccd_div_stage #(
  parameter int RW        = 12,
  parameter int RST_RATIO = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic [RW-1:0] ratio_req,
  output logic          out_en,
  output logic [RW-1:0] ratio_act
);

  logic [RW-1:0] cnt_q;
  logic [RW-1:0] act_q;
  logic          tc;

  assign tc = in_en && (cnt_q == act_q - RW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= RW'(RST_RATIO);
    end else if (in_en) begin
      if (tc) begin
        cnt_q <= '0;
        act_q <= ratio_req;
      end else begin
        cnt_q <= cnt_q + RW'(1);
      end
    end
  end

  assign out_en    = tc;
  assign ratio_act = act_q;

  AST_REQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_req != '0); // R1
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q); // R8
  AST_ACT_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(tc)); // R8
  AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> in_en); // R6

endmodule

// File: rtl/codec_clkdiv_chain.sv
module codec_clkdiv_chain
  import ccd_pkg::*;
#(
  parameter int MDIV_MAX = 5,
  parameter int SCLK_MAX = 8,
  parameter int FS_MAX   = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [6:0] cfg_data,
  output logic       dmclk_en,
  output logic       sclk_en,
  output logic       fs_strobe
);

  localparam int MW = $clog2(MDIV_MAX + 1);
  localparam int SW = $clog2(SCLK_MAX + 1);
  localparam int FW = $clog2(FS_MAX + 1);

  ccd_cfg_t      cfg_q;
  logic [MW-1:0] m_req, m_act;
  logic [SW-1:0] s_req, s_act;
  logic [FW-1:0] f_req, f_act;

  ccd_cfg_reg i_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cfg_wr),
    .din  (cfg_data),
    .q    (cfg_q)
  );

  assign m_req = MW'(master_ratio(cfg_q.mdiv));
  assign s_req = SW'(halving_ratio(SCLK_MAX, cfg_q.sdiv));
  assign f_req = FW'(halving_ratio(FS_MAX, cfg_q.fsdiv));

  ccd_div_stage #(.RW(MW), .RST_RATIO(1)) i_mstage (
    .clk(clk), .rst_n(rst_n), .in_en(1'b1),
    .ratio_req(m_req), .out_en(dmclk_en), .ratio_act(m_act)
  );

  ccd_div_stage #(.RW(SW), .RST_RATIO(SCLK_MAX)) i_sstage (
    .clk(clk), .rst_n(rst_n), .in_en(dmclk_en),
    .ratio_req(s_req), .out_en(sclk_en), .ratio_act(s_act)
  );

  ccd_div_stage #(.RW(FW), .RST_RATIO(FS_MAX)) i_fstage (
    .clk(clk), .rst_n(rst_n), .in_en(dmclk_en),
    .ratio_req(f_req), .out_en(fs_strobe), .ratio_act(f_act)
  );

  AST_MDIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_act >= MW'(1)) && (m_act <= MW'(MDIV_MAX))); // R2
  AST_SCLK_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(s_act)); // R3
  AST_FS_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(f_act)); // R4
  AST_SCLK_WITH_DM: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_en |-> dmclk_en); // R6
  AST_FS_WITH_DM: assert property (@(posedge clk) disable iff (!rst_n)
    fs_strobe |-> dmclk_en); // R6

endmodule

// File: tb/test_codec_clkdiv_chain.sv
module test_codec_clkdiv_chain;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [6:0] cfg_data = '0;
  logic       dmclk_en, sclk_en, fs_strobe;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  codec_clkdiv_chain i_codec_clkdiv_chain (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .dmclk_en(dmclk_en), .sclk_en(sclk_en), .fs_strobe(fs_strobe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks = n_checks + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return dmclk_en;
      1: return sclk_en;
      default: return fs_strobe;
    endcase
  endfunction

  task automatic write_cfg(input int m, input int s, input int f);
    @(negedge clk);
    cfg_data = {3'(m), 2'(s), 2'(f)};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // cycles between two consecutive pulses of the selected output
  task automatic measure(input int sel, output int iv);
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!pick(sel) && guard < 20000);
    iv = 0;
    do begin @(negedge clk); iv++; end while (!pick(sel) && iv < 20000);
  endtask

  function automatic int exp_m(input int c);
    return (c <= 4) ? c + 1 : 1;
  endfunction

  initial begin
    int iv;
    int idx;
    int first_s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R5: defaults straight after reset
    check("R5 dmclk_en first cycle", int'(dmclk_en), 1);
    idx = 0;
    first_s = -1;
    while (!fs_strobe && idx < 5000) begin
      if (sclk_en && first_s < 0) first_s = idx;
      @(negedge clk);
      idx++;
    end
    check("R5 first sclk_en index", first_s, 7);
    check("R5 first fs_strobe index", idx, 2047);

    // R1 R2 R3 R7: master and serial sweep, sample at fastest code
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        write_cfg(m, s, 3);
        repeat (100) @(negedge clk);
        measure(0, iv);
        check(m <= 4 ? "R1 dmclk period" : "R2 dmclk period", iv, exp_m(m));
        measure(1, iv);
        check("R3 sclk period", iv, exp_m(m) * (8 / (1 << s)));
      end
      measure(2, iv);
      measure(2, iv);
      check("R7 fs period with master code", iv, 256 * exp_m(m));
    end

    // R4: sample codes at divide-by-one
    for (int f = 3; f >= 0; f--) begin
      write_cfg(0, 0, f);
      measure(2, iv);
      check("R4 fs period", iv, 2048 >> f);
    end

    // R6: pulse widths with master /3
    write_cfg(2, 0, 3);
    measure(2, iv);
    measure(2, iv);
    check("R6 fs_strobe with dmclk_en", int'(dmclk_en), 1);
    @(negedge clk);
    check("R6 fs_strobe one cycle", int'(fs_strobe), 0);
    do @(negedge clk); while (!sclk_en);
    @(negedge clk);
    check("R6 sclk_en one cycle", int'(sclk_en), 0);

    // R8: mid-period change from /8 to /1
    write_cfg(0, 0, 3);
    repeat (40) @(negedge clk);
    do @(negedge clk); while (!sclk_en);
    repeat (3) @(negedge clk);
    cfg_data = {3'd0, 2'd3, 2'd3};
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    idx = 4;
    while (!sclk_en && idx < 100) begin
      @(negedge clk);
      idx++;
    end
    check("R8 old period completes", idx, 8);
    @(negedge clk);
    check("R8 new period next", int'(sclk_en), 1);

    // R9: data changes without the strobe are ignored
    write_cfg(2, 1, 3);
    repeat (60) @(negedge clk);
    cfg_data = {3'd4, 2'd3, 2'd0};
    repeat (100) @(negedge clk);
    measure(0, iv);
    check("R9 dmclk unchanged", iv, 3);
    measure(1, iv);
    check("R9 sclk unchanged", iv, 12);
    measure(2, iv);
    check("R9 fs unchanged", iv, 768);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule